// File: doc/BRIEF.md
# Double-Buffered Function Word Store with Program-Cycle Sequencer

This block sits at the edge of a cell array that evaluates piecewise-linear functions. It keeps two 32-bit function words, named F and G, that every cell reads in parallel. Each word arrives one bit at a time through its own serial input into a staging shift register. A transfer strobe copies both staging registers into output holding registers. The array sees only those holding registers, so the next function can be shifted in while the current one is still being evaluated.

The same block runs the program cycle that the array steps through. A start pulse begins a cycle with one reset-phase clock. Compute clocks follow, and during them a shared ramp counts upward from zero. A single store-phase clock ends the cycle. The number of compute clocks depends on two mode inputs that are sampled at start: one selects one operand or two, and one selects 1-bit (binary) data or 6-bit grey data.

Top module: `progword_buffer`

## Requirements
- R1: While reset is held and on the cycle after it is released, both function word outputs, the ramp and all three phase strobes are zero.
- R2: Each staging register moves in one bit per clock while its shift enable is high. The new bit enters at bit 31 and the contents move toward bit 0, so after 32 shifts the first bit sent sits in bit 0 (LSB first). When its enable is low, the staging register keeps its value.
- R3: The F and G staging registers have separate data and enable inputs. Shifting one of them leaves the other unchanged.
- R4: A transfer strobe sampled while no cycle is running, or on the reset-phase clock, copies both staging registers to the outputs on the next clock. The value copied is the staging content from before any shift in that same clock.
- R5: A transfer strobe sampled during a compute-phase or store-phase clock is ignored, and both outputs keep their values.
- R6: Shifting new bits into a staging register while a cycle is running does not change either output.
- R7: A start sampled with no cycle running raises the reset strobe on the next clock. A start sampled while a cycle is running is ignored.
- R8: A cycle lasts, from the reset strobe to the store strobe inclusive: 65 clocks for grey single-operand, 129 for grey dual-operand, 2 for binary single-operand (no compute clock) and 3 for binary dual-operand.
- R9: On compute clocks the ramp shows 0, 1, 2 and so on, one step per clock. On every other clock the ramp is 0.
- R10: The reset, compute and store strobes are never high together. Reset and store each last one clock. The clock after store has no strobe unless a new start arrived while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sdi_f | input | 1 | Serial data for the F staging register |
| shift_f | input | 1 | Shift enable for F |
| sdi_g | input | 1 | Serial data for the G staging register |
| shift_g | input | 1 | Shift enable for G |
| xfer | input | 1 | Transfer strobe, staging to outputs |
| start | input | 1 | Begin a program cycle |
| op_dual | input | 1 | Mode at start: two operands |
| op_bin | input | 1 | Mode at start: binary data |
| f_word | output | 32 | Held F word broadcast to the array |
| g_word | output | 32 | Held G word broadcast to the array |
| ramp | output | 7 | Shared ramp, counting during compute |
| ph_reset | output | 1 | Reset-phase strobe |
| ph_compute | output | 1 | Compute-phase level |
| ph_store | output | 1 | Store-phase strobe |

## Verification
The bench targets the window edges for a transfer. A strobe placed on the reset-phase clock must take effect, while a strobe placed mid-compute must not. A design that gates transfers only on "idle" would miss the first case, and one that never gates them would corrupt a running cycle. A transfer issued in the same clock as a shift checks that the pre-shift value is copied; an off-by-one here would show up as an output shifted by one bit. Each of the four mode combinations is timed end to end, including the binary single-operand case with no compute clock, where a sequencer that always spends one compute clock would stretch the cycle to 3. The bench also checks that the ramp never stops one step short and that a stray start during compute adds no second cycle.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RST  = 2'd1,
    PH_CMP  = 2'd2,
    PH_STR  = 2'd3
  } phase_t;
endpackage

// File: rtl/pm_lane.sv
// One serial staging register plus its output holding register.
module pm_lane #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sdi,
  input  logic         shift_en,
  input  logic         load,
  output logic [W-1:0] word
);
  logic [W-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
    end else if (shift_en) begin
      stage <= {sdi, stage[W-1:1]};
    end
  end

  // The copy takes the staging value from before this clock's shift.
  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
    end else if (load) begin
      word <= stage;
    end
  end

  assert_shift_in_R2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (stage[W-2:0] == $past(stage[W-1:1])) && (stage[W-1] == $past(sdi)));
  assert_shift_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(stage));
endmodule

// File: rtl/pm_seq.sv
// Program-cycle sequencer: reset clock, compute clocks with ramp, store clock.
module pm_seq
  import pm_pkg::*;
#(
  parameter int RAMP_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_dual,
  input  logic              op_bin,
  output logic [RAMP_W:0]   ramp,
  output logic              ph_reset,
  output logic              ph_compute,
  output logic              ph_store,
  output logic              xfer_open
);
  localparam int RW = RAMP_W + 1;
  localparam logic [RW-1:0] N_SINGLE = RW'((1 << RAMP_W) - 1);
  localparam logic [RW-1:0] N_DUAL   = RW'((1 << RW) - 1);

  phase_t        ph;
  logic [RW-1:0] lim;
  logic [RW-1:0] lim_n;

  always_comb begin
    if (op_bin) lim_n = op_dual ? RW'(1) : '0;
    else        lim_n = op_dual ? N_DUAL : N_SINGLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= PH_IDLE;
      ramp <= '0;
      lim  <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph  <= PH_RST;
          lim <= lim_n;
        end
        PH_RST: begin
          ramp <= '0;
          ph   <= (lim == '0) ? PH_STR : PH_CMP;
        end
        PH_CMP: begin
          if (ramp == lim - 1'b1) begin
            ph   <= PH_STR;
            ramp <= '0;
          end else begin
            ramp <= ramp + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign ph_reset   = (ph == PH_RST);
  assign ph_compute = (ph == PH_CMP);
  assign ph_store   = (ph == PH_STR);
  assign xfer_open  = (ph == PH_IDLE) || (ph == PH_RST);

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ph_reset, ph_compute, ph_store}));
  assert_store_ends_R10: assert property (@(posedge clk) disable iff (rst)
    ph_store |=> !(ph_reset || ph_compute || ph_store));
  assert_ramp_rest_R9: assert property (@(posedge clk) disable iff (rst)
    !ph_compute |-> (ramp == '0));
  assert_ramp_step_R9: assert property (@(posedge clk) disable iff (rst)
    ph_compute |=> ph_store || (ph_compute && (ramp == $past(ramp) + 1'b1)));
  assert_start_R7: assert property (@(posedge clk) disable iff (rst)
    (start && !(ph_reset || ph_compute || ph_store)) |=> ph_reset);
  assert_after_reset_R8: assert property (@(posedge clk) disable iff (rst)
    ph_reset |=> (ph_compute || ph_store));
endmodule

// File: rtl/progword_buffer.sv
module progword_buffer #(
  parameter int WORD_W = 32,
  parameter int RAMP_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdi_f,
  input  logic              shift_f,
  input  logic              sdi_g,
  input  logic              shift_g,
  input  logic              xfer,
  input  logic              start,
  input  logic              op_dual,
  input  logic              op_bin,
  output logic [WORD_W-1:0] f_word,
  output logic [WORD_W-1:0] g_word,
  output logic [RAMP_W:0]   ramp,
  output logic              ph_reset,
  output logic              ph_compute,
  output logic              ph_store
);
  localparam int LANES = 2;

  logic              xfer_open;
  logic              load;
  logic [LANES-1:0]  sdi_v;
  logic [LANES-1:0]  sh_v;
  logic [WORD_W-1:0] word_v [LANES];

  assign sdi_v = {sdi_g, sdi_f};
  assign sh_v  = {shift_g, shift_f};
  assign load  = xfer && xfer_open;

  pm_seq #(.RAMP_W(RAMP_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .op_dual    (op_dual),
    .op_bin     (op_bin),
    .ramp       (ramp),
    .ph_reset   (ph_reset),
    .ph_compute (ph_compute),
    .ph_store   (ph_store),
    .xfer_open  (xfer_open)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pm_lane #(.W(WORD_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .sdi      (sdi_v[i]),
      .shift_en (sh_v[i]),
      .load     (load),
      .word     (word_v[i])
    );
  end

  assign f_word = word_v[0];
  assign g_word = word_v[1];

  assert_hold_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (ph_compute || ph_store) |=> ($stable(f_word) && $stable(g_word)));
  assert_hold_no_xfer_R6: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> ($stable(f_word) && $stable(g_word)));
endmodule

// File: tb/sim_progword_buffer.sv
module sim_progword_buffer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sdi_f = 0, shift_f = 0, sdi_g = 0, shift_g = 0;
  logic xfer = 0, start = 0, op_dual = 0, op_bin = 0;
  logic [31:0] f_word, g_word;
  logic [6:0]  ramp;
  logic ph_reset, ph_compute, ph_store;

  always #2 clk = ~clk;

  progword_buffer u0 (
    .clk(clk), .rst(rst), .sdi_f(sdi_f), .shift_f(shift_f), .sdi_g(sdi_g),
    .shift_g(shift_g), .xfer(xfer), .start(start), .op_dual(op_dual),
    .op_bin(op_bin), .f_word(f_word), .g_word(g_word), .ramp(ramp),
    .ph_reset(ph_reset), .ph_compute(ph_compute), .ph_store(ph_store)
  );

  int n_chk = 0, n_fail = 0;
  bit armed = 0, finished = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model: phase 0 idle, 1 reset, 2 compute, 3 store.
  logic [31:0] m_sf, m_sg, m_lf, m_lg;
  int m_ph, m_len, m_k;

  always @(posedge clk) begin
    if (rst) begin
      m_sf = 0; m_sg = 0; m_lf = 0; m_lg = 0; m_ph = 0; m_len = 0; m_k = 0;
      armed = 1;
    end else begin
      if (xfer && (m_ph == 0 || m_ph == 1)) begin
        m_lf = m_sf; m_lg = m_sg;
      end
      if (shift_f) m_sf = {sdi_f, m_sf[31:1]};
      if (shift_g) m_sg = {sdi_g, m_sg[31:1]};
      case (m_ph)
        0: if (start) begin
             m_ph = 1;
             m_len = (op_bin ? 1 : 64) * (op_dual ? 2 : 1) - 1;
           end
        1: begin m_k = 0; m_ph = (m_len > 0) ? 2 : 3; end
        2: if (m_k + 1 < m_len) m_k++; else begin m_k = 0; m_ph = 3; end
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (armed && !finished) begin
      check(f_word == m_lf, "R4 f_word", f_word, m_lf);
      check(g_word == m_lg, "R4 g_word", g_word, m_lg);
      check(ramp == ((m_ph == 2) ? m_k : 0), "R9 ramp", ramp, (m_ph == 2) ? m_k : 0);
      check({ph_reset, ph_compute, ph_store} == {m_ph == 1, m_ph == 2, m_ph == 3},
            "R10 strobes", {ph_reset, ph_compute, ph_store}, {m_ph == 1, m_ph == 2, m_ph == 3});
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #80000;
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  // Run one program cycle and measure its length in clocks (R8).
  task automatic run_cycle(input bit d, input bit b, input int exp, input bit xfer_at_rst, input string tag);
    int n;
    @(negedge clk); start = 1; op_dual = d; op_bin = b;
    @(negedge clk); start = 0;
    check(ph_reset, "R7 reset strobe after start", ph_reset, 1);
    if (xfer_at_rst) xfer = 1;
    n = 1;
    while (!ph_store && n < 400) begin
      @(negedge clk); xfer = 0; n++;
    end
    xfer = 0;
    check(n == exp, tag, n, exp);
  endtask

  localparam logic [31:0] PF = 32'hA5C3_0F96;
  localparam logic [31:0] PG = 32'h3C69_D21E;
  localparam logic [31:0] PN = 32'h5AF0_1234;

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: outputs at rest right after reset release
    check({f_word, g_word} == 64'd0, "R1 words zero", {f_word, g_word}, 0);
    check({ramp, ph_reset, ph_compute, ph_store} == 0, "R1 sequencer idle",
          {ramp, ph_reset, ph_compute, ph_store}, 0);

    // R2: LSB-first loading of both lanes
    for (int i = 0; i < 32; i++) begin
      shift_f = 1; sdi_f = PF[i]; shift_g = 1; sdi_g = PG[i];
      @(negedge clk);
    end
    shift_f = 0; shift_g = 0;
    check(f_word == 0, "R6 no change before transfer", f_word, 0);
    xfer = 1; @(negedge clk); xfer = 0;
    check(f_word == PF, "R2 F loaded LSB first", f_word, PF);
    check(g_word == PG, "R2 G loaded LSB first", g_word, PG);

    // R3: shift F alone by 8 zero bits; R4: transfer in the same clock as a shift
    for (int i = 0; i < 8; i++) begin
      shift_f = 1; sdi_f = 0;
      xfer = (i == 7);
      @(negedge clk);
    end
    shift_f = 0; xfer = 0;
    check(f_word == (PF >> 7), "R4 pre-shift value copied", f_word, PF >> 7);
    xfer = 1; @(negedge clk); xfer = 0;
    check(f_word == (PF >> 8), "R3 F moved alone", f_word, PF >> 8);
    check(g_word == PG, "R3 G untouched", g_word, PG);

    // R5, R6, R7: grey single cycle with shifting, a transfer and a stray start mid-compute
    @(negedge clk); start = 1; op_dual = 0; op_bin = 0;
    @(negedge clk); start = 0;
    check(ph_reset, "R7 reset strobe", ph_reset, 1);
    n = 1;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); n++;
      shift_f = 1; sdi_f = PN[i];
      xfer = (i == 10);
      start = (i == 12);
    end
    @(negedge clk); n++;
    shift_f = 0; xfer = 0; start = 0;
    check(f_word == (PF >> 8), "R5 transfer in compute ignored", f_word, PF >> 8);
    check(g_word == PG, "R6 G held during compute", g_word, PG);
    while (!ph_store && n < 400) begin @(negedge clk); n++; end
    check(n == 65, "R8 grey single length", n, 65);
    @(negedge clk);
    check(!ph_reset, "R7 stray start ignored", ph_reset, 0);

    // R4: transfer on the reset-phase clock is accepted
    run_cycle(1'b1, 1'b0, 129, 1'b1, "R8 grey dual length");
    check(f_word == PN, "R4 transfer on reset clock", f_word, PN);
    // R5: transfer on the store clock is ignored
    shift_f = 1; sdi_f = 1;
    @(negedge clk); shift_f = 0;
    run_cycle(1'b0, 1'b1, 2, 1'b0, "R8 binary single length");
    xfer = 1; @(negedge clk); xfer = 0;
    check(f_word == PN, "R5 transfer on store clock ignored", f_word, PN);
    run_cycle(1'b1, 1'b1, 3, 1'b0, "R8 binary dual length");
    @(negedge clk);
    check({ph_reset, ph_compute, ph_store} == 0, "R10 idle after store",
          {ph_reset, ph_compute, ph_store}, 0);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule